// File: doc/BRIEF.md
# Flash Row Program Sequencer

This controller programs one aligned 64-byte row of an on-chip flash array. A start command carries an address; the upper address bits select the target row. The controller raises the program-mode enable and issues a single latching write to the start address. It then waits a settle interval, raises the high-voltage enable and waits again before it asks for data. Data bytes arrive over a valid/ready interface. Each one is strobed into the array and then held for the program time before the next byte is requested.

A run ends when a byte is flagged as the last one, or when the 64th byte has been written. The controller then drops program mode, waits, drops the high voltage, waits a recovery time, and pulses done. A byte whose address lies outside the selected row is consumed but never written. It sends the controller straight into the same shutdown order and makes error pulse together with done. All five waits are counted in clock cycles by one shared down-counter that is reloaded on every state change.

Top module: `flash_row_prog`

## Requirements
- R1: While rst is high, and in the cycle after it, every output is low.
- R2: A start_i pulse seen while idle raises pgm_o and busy_o in the next cycle. A start_i pulse seen while busy_o is high has no effect on any output.
- R3: One cycle after pgm_o rises, arr_we_o pulses for one cycle with arr_addr_o equal to the start address and arr_data_o zero, while hven_o is still low.
- R4: hven_o rises exactly T_NVS cycles after the latching strobe, and byte_ready_o rises exactly T_PGS cycles after hven_o.
- R5: A byte accepted (byte_valid_i and byte_ready_o high at a clock edge) with an in-row address gives a one-cycle arr_we_o pulse in the next cycle, carrying that byte's address and data. byte_ready_o returns exactly T_PROG cycles after that strobe.
- R6: A byte is in the row when address bits [ADDR_W-1:6] equal those of the start address. An out-of-row byte produces no strobe, and pgm_o falls in the cycle after it is accepted.
- R7: A byte accepted with byte_last_i high, or the 64th byte of a run, ends the run: pgm_o falls T_PROG cycles after its strobe, and byte_ready_o stays low.
- R8: hven_o falls T_NVH cycles after pgm_o falls. T_RCV cycles later done_o pulses for one cycle and busy_o falls in that same cycle.
- R9: error_o pulses together with done_o exactly when the run accepted an out-of-row byte, and is low otherwise.
- R10: Any number of idle cycles before a byte is offered leaves byte_ready_o high and changes no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a row program run |
| start_addr_i | input | ADDR_W | Start address; selects the row and is the latching write address |
| byte_valid_i | input | 1 | A data byte is offered |
| byte_addr_i | input | ADDR_W | Address of the offered byte |
| byte_data_i | input | DATA_W | Offered data byte |
| byte_last_i | input | 1 | Offered byte is the final one of the run |
| byte_ready_o | output | 1 | Controller accepts a byte this cycle |
| pgm_o | output | 1 | Array program-mode enable |
| hven_o | output | 1 | Array high-voltage enable |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | One-cycle pulse with done_o when a byte left the row |

## Verification
The sequencer is driven through short runs that end with byte_last_i, and through a full 64-byte run that has to stop on its own count. Comparing the two separates the last-flag path from the byte-tally path. Runs with idle gaps before each byte, and with a stray start pulse in the middle of a run, show that the wait timing is tied to the handshake and not to free-running time. A run that offers an out-of-row byte part way through, and a run aimed at the top row of a page with an unaligned start address, show that the row compare uses only the upper address bits. They also show that the error path keeps the shutdown order.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_NVS,
    ST_PGS,
    ST_DATA,
    ST_PROG,
    ST_NVH,
    ST_RCV
  } prog_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_row_match.sv
module flash_row_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 6
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] test_addr,
  output logic              in_row
);

  assign in_row = (base_addr[ADDR_W-1:OFS_W] == test_addr[ADDR_W-1:OFS_W]);

endmodule

// File: rtl/flash_byte_tally.sv
module flash_byte_tally #(
  parameter int unsigned ROW_BYTES = 64,
  localparam int unsigned TW = $clog2(ROW_BYTES)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign at_last = (count_q == TW'(ROW_BYTES - 1));

endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned T_NVS     = 4,
  parameter int unsigned T_PGS     = 3,
  parameter int unsigned T_PROG    = 5,
  parameter int unsigned T_NVH     = 2,
  parameter int unsigned T_RCV     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              pgm_o,
  output logic              hven_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int unsigned OFS_W = $clog2(ROW_BYTES);
  localparam int unsigned T_MAX =
    max2(max2(max2(T_NVS, T_PGS), max2(T_PROG, T_NVH)), T_RCV);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  prog_state_t st_q, st_n;
  logic              pgm_q, pgm_n, hven_q, hven_n, we_q, we_n;
  logic              rdy_q, rdy_n, busy_q, busy_n, done_q, done_n;
  logic              err_q, err_n, bad_q, bad_n, last_q, last_n;
  logic [ADDR_W-1:0] addr_q, addr_n, start_q, start_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              tmr_load, tmr_zero, tally_clr, tally_inc, at_last, in_row;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept;

  flash_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  flash_row_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
    .base_addr(start_q), .test_addr(byte_addr_i), .in_row(in_row)
  );

  flash_byte_tally #(.ROW_BYTES(ROW_BYTES)) u_tally (
    .clk(clk), .rst(rst), .clr(tally_clr), .inc(tally_inc), .at_last(at_last)
  );

  assign accept = byte_valid_i && rdy_q;

  always_comb begin
    st_n      = st_q;
    pgm_n     = pgm_q;
    hven_n    = hven_q;
    we_n      = 1'b0;
    addr_n    = addr_q;
    data_n    = data_q;
    rdy_n     = rdy_q;
    busy_n    = busy_q;
    done_n    = 1'b0;
    err_n     = 1'b0;
    bad_n     = bad_q;
    last_n    = last_q;
    start_n   = start_q;
    tally_clr = 1'b0;
    tally_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n      = ST_LATCH;
          pgm_n     = 1'b1;
          busy_n    = 1'b1;
          start_n   = start_addr_i;
          bad_n     = 1'b0;
          last_n    = 1'b0;
          tally_clr = 1'b1;
        end
      end
      ST_LATCH: begin
        we_n   = 1'b1;
        addr_n = start_q;
        data_n = '0;
        st_n   = ST_NVS;
      end
      ST_NVS: begin
        if (tmr_zero) begin
          hven_n = 1'b1;
          st_n   = ST_PGS;
        end
      end
      ST_PGS: begin
        if (tmr_zero) begin
          rdy_n = 1'b1;
          st_n  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (accept) begin
          rdy_n = 1'b0;
          if (in_row) begin
            we_n      = 1'b1;
            addr_n    = byte_addr_i;
            data_n    = byte_data_i;
            tally_inc = 1'b1;
            last_n    = byte_last_i || at_last;
            st_n      = ST_PROG;
          end else begin
            bad_n = 1'b1;
            pgm_n = 1'b0;
            st_n  = ST_NVH;
          end
        end
      end
      ST_PROG: begin
        if (tmr_zero) begin
          if (last_q) begin
            pgm_n = 1'b0;
            st_n  = ST_NVH;
          end else begin
            rdy_n = 1'b1;
            st_n  = ST_DATA;
          end
        end
      end
      ST_NVH: begin
        if (tmr_zero) begin
          hven_n = 1'b0;
          st_n   = ST_RCV;
        end
      end
      ST_RCV: begin
        if (tmr_zero) begin
          busy_n = 1'b0;
          done_n = 1'b1;
          err_n  = bad_q;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // the shared wait counter is reloaded on every state change
  always_comb begin
    tmr_load = (st_n != st_q);
    unique case (st_n)
      ST_NVS:  tmr_val = CNT_W'(T_NVS - 1);
      ST_PGS:  tmr_val = CNT_W'(T_PGS - 1);
      ST_PROG: tmr_val = CNT_W'(T_PROG - 1);
      ST_NVH:  tmr_val = CNT_W'(T_NVH - 1);
      ST_RCV:  tmr_val = CNT_W'(T_RCV - 1);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pgm_q   <= 1'b0;
      hven_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdy_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bad_q   <= 1'b0;
      last_q  <= 1'b0;
      start_q <= '0;
    end else begin
      st_q    <= st_n;
      pgm_q   <= pgm_n;
      hven_q  <= hven_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      rdy_q   <= rdy_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
      err_q   <= err_n;
      bad_q   <= bad_n;
      last_q  <= last_n;
      start_q <= start_n;
    end
  end

  assign byte_ready_o = rdy_q;
  assign pgm_o        = pgm_q;
  assign hven_o       = hven_q;
  assign arr_we_o     = we_q;
  assign arr_addr_o   = addr_q;
  assign arr_data_o   = data_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign error_o      = err_q;

endmodule

// File: rtl/flash_row_prog_chk.sv
module flash_row_prog_chk (
  input logic clk,
  input logic rst,
  input logic byte_ready_o,
  input logic pgm_o,
  input logic hven_o,
  input logic arr_we_o,
  input logic busy_o,
  input logic done_o,
  input logic error_o
);

  assert_latch_after_pgm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pgm_o) |=> (arr_we_o && !hven_o));

  assert_strobe_in_pgm_R5: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> pgm_o);

  assert_hven_rise_in_pgm_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hven_o) |-> pgm_o);

  assert_ready_under_hv_R4: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> (hven_o && pgm_o && busy_o));

  assert_hven_fall_after_pgm_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(hven_o) |-> !pgm_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && !hven_o && !pgm_o));

  assert_error_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    error_o |-> done_o);

  assert_pgm_with_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pgm_o) |-> $rose(busy_o));

endmodule

bind flash_row_prog flash_row_prog_chk u_chk (.*);

// File: tb/flash_row_prog_test.sv
module flash_row_prog_test;

  localparam int AW = 16, DW = 8;
  localparam int T_NVS = 4, T_PGS = 3, T_PROG = 5, T_NVH = 2, T_RCV = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, byte_valid_i = 1'b0, byte_last_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0, byte_addr_i = '0;
  logic [DW-1:0] byte_data_i = '0;
  logic byte_ready_o, pgm_o, hven_o, arr_we_o, busy_o, done_o, error_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data_o;

  int checks = 0, errors = 0, cyc = 0, strobes = 0;

  flash_row_prog uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_valid_i(byte_valid_i), .byte_addr_i(byte_addr_i),
    .byte_data_i(byte_data_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .pgm_o(pgm_o), .hven_o(hven_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: phase number plus remaining wait cycles
  int ph = 0, tw = 0, nbytes = 0;
  bit m_pgm, m_hven, m_we, m_rdy, m_busy, m_done, m_err, bad, lastf;
  logic [AW-1:0] m_addr, m_start;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_pgm = 0; m_hven = 0; m_we = 0; m_rdy = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_addr = '0; m_data = '0;
    end else begin
      bit take;
      take = byte_valid_i && m_rdy;
      m_we = 0; m_done = 0; m_err = 0;
      case (ph)
        0: if (start_i) begin
             ph = 1; m_pgm = 1; m_busy = 1; m_start = start_addr_i;
             nbytes = 0; bad = 0;
           end
        1: begin m_we = 1; m_addr = m_start; m_data = '0; ph = 2; tw = T_NVS; end
        2: begin tw--; if (tw == 0) begin m_hven = 1; ph = 3; tw = T_PGS; end end
        3: begin tw--; if (tw == 0) begin m_rdy = 1; ph = 4; end end
        4: if (take) begin
             m_rdy = 0;
             if ((byte_addr_i >> 6) == (m_start >> 6)) begin
               m_we = 1; m_addr = byte_addr_i; m_data = byte_data_i;
               nbytes++; lastf = byte_last_i || (nbytes == 64);
               ph = 5; tw = T_PROG;
             end else begin
               bad = 1; m_pgm = 0; ph = 6; tw = T_NVH;
             end
           end
        5: begin tw--; if (tw == 0) begin
             if (lastf) begin m_pgm = 0; ph = 6; tw = T_NVH; end
             else begin m_rdy = 1; ph = 4; end
           end end
        6: begin tw--; if (tw == 0) begin m_hven = 0; ph = 7; tw = T_RCV; end end
        7: begin tw--; if (tw == 0) begin
             m_busy = 0; m_done = 1; m_err = bad; ph = 0;
           end end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R6 R7 pgm_o", 32'(pgm_o), 32'(m_pgm));
      chk("R4 R8 hven_o", 32'(hven_o), 32'(m_hven));
      chk("R3 R5 R6 arr_we_o", 32'(arr_we_o), 32'(m_we));
      chk("R4 R5 R10 byte_ready_o", 32'(byte_ready_o), 32'(m_rdy));
      chk("R2 busy_o", 32'(busy_o), 32'(m_busy));
      chk("R8 done_o", 32'(done_o), 32'(m_done));
      chk("R9 error_o", 32'(error_o), 32'(m_err));
      if (m_we) begin
        chk("R3 R5 arr_addr_o", 32'(arr_addr_o), 32'(m_addr));
        chk("R3 R5 arr_data_o", 32'(arr_data_o), 32'(m_data));
      end
      if (arr_we_o) strobes++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic start_run(input logic [AW-1:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic l, input int gap);
    while (!byte_ready_o) @(negedge clk);
    repeat (gap) @(negedge clk);
    byte_valid_i = 1'b1; byte_addr_i = a; byte_data_i = d; byte_last_i = l;
    @(negedge clk);
    byte_valid_i = 1'b0; byte_last_i = 1'b0;
  endtask

  // n bytes from row base; index bad_at (if >= 0) is placed in the next row
  task automatic run(input logic [AW-1:0] sa, input int n, input int bad_at,
                     input bit use_last, input int gap, input bit poke_start);
    logic [AW-1:0] base;
    int exp_str;
    base = {sa[AW-1:6], 6'd0};
    strobes = 0;
    start_run(sa);
    if (poke_start) begin
      repeat (3) @(negedge clk);
      start_run(16'h0040);
    end
    exp_str = 1;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = base + AW'(i);
      if (i == bad_at) a = base + 16'h0040 + AW'(i);
      send(a, DW'(8'h5A ^ i), use_last && (i == n - 1), gap);
      if (i == bad_at) break;
      exp_str++;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk("R5 R6 strobe count", 32'(strobes), 32'(exp_str));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        32'({byte_ready_o, pgm_o, hven_o, arr_we_o, busy_o, done_o, error_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 32'({pgm_o, hven_o, busy_o, done_o}), 32'd0);
    run(16'h1200, 3, -1, 1'b1, 0, 1'b0);
    run(16'h12C5, 4, -1, 1'b1, 3, 1'b1);
    run(16'h3400, 64, -1, 1'b0, 0, 1'b0);
    run(16'h5680, 5, 2, 1'b1, 1, 1'b0);
    run(16'h56BF, 1, -1, 1'b1, 7, 1'b0);
    run(16'h7000, 2, 0, 1'b1, 0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 idle after runs", 32'({pgm_o, hven_o, busy_o}), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule